// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns single requests from a processor core into timed read and write cycles on a 20-bit external memory bus. A request carries an address, a size (one byte or a 16-bit word), a direction, and write data. The block accepts a request only while it is idle. It then steps through a one-clock address phase, a data phase of two clocks and a one-clock recovery. For reads, it returns the captured data together with a one-clock done pulse.

Two mode inputs shape the pins. The first selects the bus mode. In multiplexed mode, address bits 19:16 have their own lines and bits 15:0 share the address/data lines. In demultiplexed mode, all twenty address bits have dedicated lines and the shared lines carry only data. The second mode input gives the meaning of the upper byte pin: either an active-low byte-high enable, or an active-low write strobe for the high byte that pairs with a write strobe for the low byte. The shared data lines are modelled as a separate output, output-enable and input, so an outer pad ring can build the tri-state buffer. Both mode inputs are sampled when a request is accepted.

Top module: `ext_bus_seq`

## Requirements
- R1: Reset and idle state. While reset is held or no cycle is running, the following pins are all inactive: `latch_stb`, `rd_n`, `wr_lo_n`, `upper_n`, `ad_oe`, `busy` and `done`. Inactive means `latch_stb` 0, the three strobes 1, and `ad_oe`, `busy` and `done` 0. A reset in mid-cycle returns the block to idle.
- R2: Phase order. A request seen at a clock edge while idle starts a cycle, and `busy` goes high from the next clock. The cycle then runs for four clocks in this order:
  - one clock with `latch_stb` high;
  - two clocks with `rd_n` low (read) or a write strobe low (write);
  - one recovery clock with every strobe inactive.
  After that, `busy` falls.
- R3: `done` is high for exactly the one clock that follows the data phase, and low at all other times.
- R4: Multiplexed mode (`cfg_muxed`=1). During the address phase, `ad_oe` is 1 and `ad_out` carries bus address bits 15:0. `bus_a_lo` stays 0. `bus_a_hi` carries address bits 19:16 from the address phase through the data phase.
- R5: Demultiplexed mode (`cfg_muxed`=0). `bus_a_hi` and `bus_a_lo` carry the full bus address from the address phase through the data phase. During the address phase, `ad_oe` is 0.
- R6: Reads.
  - `ad_oe` is 0 throughout the data phase of a read, in both modes.
  - `ad_in` is sampled at the clock edge that ends the data phase, and `rdata` holds the result while `done` is high.
  - A word read returns `ad_in`.
  - A byte read returns the selected half in `rdata[7:0]`, with `rdata[15:8]` = 0. Bus A0=0 selects bits 7:0 and A0=1 selects bits 15:8.
- R7: Address bit A0 on the bus. A word access drives A0=0, so the address is aligned down. A byte access drives A0 = `req_addr[0]`, where 1 means the high byte.
- R8: Byte-enable mode (`cfg_upper_is_bhe`=1).
  - `upper_n` is 0 from the address phase through the data phase for word and high-byte accesses, and 1 for low-byte accesses.
  - `wr_lo_n` acts as the general write strobe and is 0 during the data phase of every write.
- R9: Write-high mode (`cfg_upper_is_bhe`=0).
  - `upper_n` is 0 only during the data phase of writes that touch the high byte (word, or byte with A0=1). It is never 0 for reads or during the address phase.
  - `wr_lo_n` is 0 only during the data phase of writes that touch the low byte (word, or byte with A0=0).
- R10: Write data. During the data phase of a write, `ad_oe` is 1. `ad_out` carries `req_wdata` for a word write. For a byte write, it carries `req_wdata[7:0]` copied onto both halves.
- R11: A request presented while `busy` is 1 is ignored. The running cycle's address is unchanged, and no new cycle starts once the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted only when idle |
| req_addr | input | 20 | Request byte address |
| req_word | input | 1 | 1 = 16-bit word, 0 = single byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| cfg_muxed | input | 1 | 1 = multiplexed bus, 0 = demultiplexed |
| cfg_upper_is_bhe | input | 1 | 1 = upper pin is byte-high enable, 0 = write-high strobe |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read result, valid with done |
| latch_stb | output | 1 | Active-high address-latch pulse |
| bus_a_hi | output | 4 | Address lines 19:16 |
| bus_a_lo | output | 16 | Dedicated address lines 15:0 (demultiplexed mode) |
| ad_out | output | 16 | Shared address/data lines, driven value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | 16 | Shared address/data lines, received value |
| upper_n | output | 1 | Byte-high enable or write-high strobe, active low |
| wr_lo_n | output | 1 | Write strobe (write-low in write-high mode), active low |
| rd_n | output | 1 | Read strobe, active low |

## Verification
The hardest case to reach from the ports is a request that arrives in the middle of a running cycle. From outside, it must show no effect at all: the current address does not change, and no further cycle appears after the block goes idle. The bench raises `req_valid` with a different address during the first data clock and drops it before the recovery clock ends. It then checks the address lines in the second data clock and watches the strobe pins for two idle clocks. Getting each mode pair to meet each access shape is done by a vector table that crosses both mode inputs with read and write, word and byte, and both values of A0.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ADDR  = 2'd1,
      PH_DATA  = 2'd2,
      PH_RECOV = 2'd3
   } phase_e;

   typedef struct packed {
      logic muxed;
      logic upper_is_bhe;
   } bus_cfg_t;

endpackage

// File: rtl/ebs_phase_ctrl.sv
module ebs_phase_ctrl
   import ebs_pkg::*;
#(
   parameter int DATA_CLKS  = 2,
   parameter int RECOV_CLKS = 1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   output phase_e phase,
   output logic   last_data
);

   localparam int CNT_MAX = (DATA_CLKS > RECOV_CLKS) ? DATA_CLKS : RECOV_CLKS;
   localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
   localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(DATA_CLKS - 1);
   localparam logic [CNT_W-1:0] RECOV_LAST = CNT_W'(RECOV_CLKS - 1);

   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               cnt_q <= '0;
               if (start) phase_q <= PH_ADDR;
            end
            PH_ADDR: begin
               cnt_q   <= '0;
               phase_q <= PH_DATA;
            end
            PH_DATA: begin
               if (cnt_q == DATA_LAST) begin
                  cnt_q   <= '0;
                  phase_q <= PH_RECOV;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_RECOV: begin
               if (cnt_q == RECOV_LAST) begin
                  cnt_q   <= '0;
                  phase_q <= PH_IDLE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               cnt_q   <= '0;
               phase_q <= PH_IDLE;
            end
         endcase
      end
   end

   assign phase     = phase_q;
   assign last_data = (phase_q == PH_DATA) && (cnt_q == DATA_LAST);

endmodule

// File: rtl/ebs_lane_steer.sv
module ebs_lane_steer #(
   parameter int DATA_W = 16
) (
   input  logic              word,
   input  logic              a0,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] wr_bus,
   output logic [DATA_W-1:0] rd_val
);

   localparam int LANES  = 2;
   localparam int LANE_W = DATA_W / LANES;

   logic [LANE_W-1:0] lane_in [LANES];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign wr_bus[l*LANE_W +: LANE_W] = word ? wdata[l*LANE_W +: LANE_W]
                                               : wdata[LANE_W-1:0];
      assign lane_in[l] = ad_in[l*LANE_W +: LANE_W];
   end

   always_comb begin
      if (word) rd_val = ad_in;
      else      rd_val = {{(DATA_W-LANE_W){1'b0}}, lane_in[a0]};
   end

endmodule

// File: rtl/ebs_pin_drive.sv
module ebs_pin_drive
   import ebs_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int HI_W   = 4
) (
   input  phase_e            phase,
   input  bus_cfg_t          cfg,
   input  logic              write,
   input  logic              word,
   input  logic              a0,
   input  logic [HI_W-1:0]   addr_hi,
   input  logic [DATA_W-1:0] addr_lo,
   input  logic [DATA_W-1:0] wr_bus,
   output logic              latch_stb,
   output logic [HI_W-1:0]   bus_a_hi,
   output logic [DATA_W-1:0] bus_a_lo,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic              upper_n,
   output logic              wr_lo_n,
   output logic              rd_n
);

   logic in_addr, in_data, in_cycle, hi_touch, lo_touch, wr_data, addr_on_ad;

   assign in_addr    = (phase == PH_ADDR);
   assign in_data    = (phase == PH_DATA);
   assign in_cycle   = in_addr | in_data;
   assign hi_touch   = word | a0;
   assign lo_touch   = word | ~a0;
   assign wr_data    = in_data & write;
   assign addr_on_ad = in_addr & cfg.muxed;

   assign latch_stb = in_addr;
   assign bus_a_hi  = in_cycle ? addr_hi : '0;
   assign bus_a_lo  = (in_cycle && !cfg.muxed) ? addr_lo : '0;
   assign ad_oe     = addr_on_ad | wr_data;
   assign ad_out    = addr_on_ad ? addr_lo : (wr_data ? wr_bus : '0);
   assign rd_n      = ~(in_data & ~write);

   always_comb begin
      if (cfg.upper_is_bhe) begin
         upper_n = ~(in_cycle & hi_touch);
         wr_lo_n = ~wr_data;
      end else begin
         upper_n = ~(wr_data & hi_touch);
         wr_lo_n = ~(wr_data & lo_touch);
      end
   end

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
   import ebs_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int DATA_W     = 16,
   parameter int DATA_CLKS  = 2,
   parameter int RECOV_CLKS = 1,
   localparam int HI_W      = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_word,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              cfg_muxed,
   input  logic              cfg_upper_is_bhe,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              latch_stb,
   output logic [HI_W-1:0]   bus_a_hi,
   output logic [DATA_W-1:0] bus_a_lo,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   input  logic [DATA_W-1:0] ad_in,
   output logic              upper_n,
   output logic              wr_lo_n,
   output logic              rd_n
);

   if (DATA_W != 16) begin : g_bad_data_w
      $error("ext_bus_seq: DATA_W must be 16 (two byte lanes)");
   end
   if (ADDR_W <= DATA_W) begin : g_bad_addr_w
      $error("ext_bus_seq: ADDR_W must exceed DATA_W");
   end
   if (DATA_CLKS < 1 || RECOV_CLKS < 1) begin : g_bad_clks
      $error("ext_bus_seq: phase lengths must be at least one clock");
   end

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic              word;
      logic              write;
      logic [DATA_W-1:0] wdata;
   } req_t;

   phase_e            phase;
   logic              last_data;
   logic              start;
   req_t              req_q;
   bus_cfg_t          cfg_q;
   logic              done_q;
   logic [DATA_W-1:0] rdata_q;
   logic              bus_a0;
   logic [DATA_W-1:0] bus_addr_lo;
   logic [DATA_W-1:0] wr_bus;
   logic [DATA_W-1:0] rd_val;

   assign start = req_valid && (phase == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= '0;
         cfg_q <= '0;
      end else if (start) begin
         req_q <= '{addr: req_addr, word: req_word, write: req_write, wdata: req_wdata};
         cfg_q <= '{muxed: cfg_muxed, upper_is_bhe: cfg_upper_is_bhe};
      end
   end

   ebs_phase_ctrl #(
      .DATA_CLKS (DATA_CLKS),
      .RECOV_CLKS(RECOV_CLKS)
   ) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .phase    (phase),
      .last_data(last_data)
   );

   assign bus_a0      = req_q.word ? 1'b0 : req_q.addr[0];
   assign bus_addr_lo = {req_q.addr[DATA_W-1:1], bus_a0};

   ebs_lane_steer #(.DATA_W(DATA_W)) u_lane (
      .word  (req_q.word),
      .a0    (bus_a0),
      .wdata (req_q.wdata),
      .ad_in (ad_in),
      .wr_bus(wr_bus),
      .rd_val(rd_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         done_q <= last_data;
         if (last_data && !req_q.write) rdata_q <= rd_val;
      end
   end

   ebs_pin_drive #(
      .DATA_W(DATA_W),
      .HI_W  (HI_W)
   ) u_pins (
      .phase    (phase),
      .cfg      (cfg_q),
      .write    (req_q.write),
      .word     (req_q.word),
      .a0       (bus_a0),
      .addr_hi  (req_q.addr[ADDR_W-1:DATA_W]),
      .addr_lo  (bus_addr_lo),
      .wr_bus   (wr_bus),
      .latch_stb(latch_stb),
      .bus_a_hi (bus_a_hi),
      .bus_a_lo (bus_a_lo),
      .ad_out   (ad_out),
      .ad_oe    (ad_oe),
      .upper_n  (upper_n),
      .wr_lo_n  (wr_lo_n),
      .rd_n     (rd_n)
   );

   assign busy  = (phase != PH_IDLE);
   assign done  = done_q;
   assign rdata = rdata_q;

endmodule

// File: rtl/ebs_checker.sv
module ebs_checker #(
   parameter int HI_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            done,
   input logic            latch_stb,
   input logic            rd_n,
   input logic            wr_lo_n,
   input logic            upper_n,
   input logic            ad_oe,
   input logic [HI_W-1:0] bus_a_hi
);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!latch_stb && rd_n && wr_lo_n && upper_n && !ad_oe && !done));

   assert_latch_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      latch_stb |=> !latch_stb);

   assert_latch_before_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      latch_stb |=> (!rd_n || !wr_lo_n || !upper_n));

   assert_no_rd_wr_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_lo_n));

   assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy && rd_n && wr_lo_n && !latch_stb));

   assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !wr_lo_n) |-> $stable(bus_a_hi));

   assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe);

   assert_start_from_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      latch_stb |-> !$past(busy));

endmodule

bind ext_bus_seq ebs_checker #(.HI_W(HI_W)) u_ebs_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .latch_stb(latch_stb),
   .rd_n     (rd_n),
   .wr_lo_n  (wr_lo_n),
   .upper_n  (upper_n),
   .ad_oe    (ad_oe),
   .bus_a_hi (bus_a_hi)
);

// File: tb/tb_ext_bus_seq.sv
module tb_ext_bus_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [19:0] req_addr = '0;
   logic        req_word = 1'b0;
   logic        req_write = 1'b0;
   logic [15:0] req_wdata = '0;
   logic        cfg_muxed = 1'b1;
   logic        cfg_upper_is_bhe = 1'b1;
   logic [15:0] ad_in = '0;
   logic        busy, done, latch_stb, ad_oe, upper_n, wr_lo_n, rd_n;
   logic [15:0] rdata, bus_a_lo, ad_out;
   logic [3:0]  bus_a_hi;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   ext_bus_seq dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
      .cfg_muxed(cfg_muxed), .cfg_upper_is_bhe(cfg_upper_is_bhe),
      .busy(busy), .done(done), .rdata(rdata), .latch_stb(latch_stb),
      .bus_a_hi(bus_a_hi), .bus_a_lo(bus_a_lo), .ad_out(ad_out), .ad_oe(ad_oe),
      .ad_in(ad_in), .upper_n(upper_n), .wr_lo_n(wr_lo_n), .rd_n(rd_n)
   );

   typedef struct packed {
      logic        mux;
      logic        bhe;
      logic        wr;
      logic        word;
      logic [19:0] addr;
      logic [15:0] wdata;
      logic [15:0] adin;
      logic        up_a;   // upper_n expected in address phase
      logic        up_d;   // upper_n expected in data phase
      logic        wrl;    // wr_lo_n expected in data phase
      logic [15:0] ead;    // ad_out expected in write data phase
      logic [15:0] erd;    // rdata expected for reads
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b1,1'b0,1'b1,20'h51235,16'h0000,16'hABCD,1'b0,1'b0,1'b1,16'h0000,16'hABCD},
      '{1'b1,1'b1,1'b0,1'b0,20'hA0011,16'h0000,16'hBEEF,1'b0,1'b0,1'b1,16'h0000,16'h00BE},
      '{1'b0,1'b1,1'b0,1'b0,20'h30010,16'h0000,16'hBEEF,1'b1,1'b1,1'b1,16'h0000,16'h00EF},
      '{1'b1,1'b1,1'b1,1'b1,20'hFFFFE,16'h1357,16'h0000,1'b0,1'b0,1'b0,16'h1357,16'h0000},
      '{1'b0,1'b1,1'b1,1'b0,20'h04002,16'h00A5,16'h0000,1'b1,1'b1,1'b0,16'hA5A5,16'h0000},
      '{1'b1,1'b0,1'b1,1'b0,20'h78001,16'h003C,16'h0000,1'b1,1'b0,1'b1,16'h3C3C,16'h0000},
      '{1'b0,1'b0,1'b1,1'b0,20'h20000,16'h0077,16'h0000,1'b1,1'b1,1'b0,16'h7777,16'h0000},
      '{1'b1,1'b0,1'b1,1'b1,20'h10102,16'h9ABC,16'h0000,1'b1,1'b0,1'b0,16'h9ABC,16'h0000},
      '{1'b0,1'b0,1'b0,1'b1,20'h66667,16'h0000,16'h1111,1'b1,1'b1,1'b1,16'h0000,16'h1111}
   };

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_lo(input logic [19:0] a, input logic w);
      return w ? {a[15:1], 1'b0} : a[15:0];   // R7 alignment rule
   endfunction

   task automatic run_vec(input vec_t v);
      logic [15:0] lo;
      lo = exp_lo(v.addr, v.word);
      cfg_muxed = v.mux; cfg_upper_is_bhe = v.bhe;
      req_addr = v.addr; req_word = v.word; req_write = v.wr;
      req_wdata = v.wdata; ad_in = v.adin; req_valid = 1'b1;
      @(negedge clk);   // address phase
      req_valid = 1'b0;
      chk("R2", "latch_stb addr", latch_stb, 1);
      chk("R2", "busy addr", busy, 1);
      chk("R5", "bus_a_hi addr", bus_a_hi, v.addr[19:16]);
      if (v.mux) begin
         chk("R4", "ad_oe addr", ad_oe, 1);
         chk("R4", "ad_out addr", ad_out, lo);
         chk("R4", "bus_a_lo muxed", bus_a_lo, 0);
      end else begin
         chk("R5", "ad_oe addr", ad_oe, 0);
         chk("R5", "bus_a_lo addr", bus_a_lo, lo);
      end
      chk(v.bhe ? "R8" : "R9", "upper_n addr", upper_n, v.up_a);
      chk("R2", "strobes idle in addr", {rd_n, wr_lo_n}, 2'b11);
      for (int d = 0; d < 2; d++) begin
         @(negedge clk);   // data phase
         chk("R2", "latch_stb data", latch_stb, 0);
         chk("R2", "rd_n data", rd_n, v.wr);
         chk(v.bhe ? "R8" : "R9", "wr_lo_n data", wr_lo_n, v.wrl);
         chk(v.bhe ? "R8" : "R9", "upper_n data", upper_n, v.up_d);
         chk(v.wr ? "R10" : "R6", "ad_oe data", ad_oe, v.wr);
         if (v.wr) chk("R10", "ad_out data", ad_out, v.ead);
         if (!v.mux) chk("R5", "bus_a_lo data", bus_a_lo, lo);
         chk("R5", "bus_a_hi data", bus_a_hi, v.addr[19:16]);
         chk("R3", "done in data", done, 0);
      end
      @(negedge clk);   // recovery
      chk("R3", "done recovery", done, 1);
      chk("R2", "busy recovery", busy, 1);
      chk("R2", "strobes recovery", {latch_stb, rd_n, wr_lo_n, upper_n}, 4'b0111);
      if (!v.wr) chk("R6", "rdata", rdata, v.erd);
      @(negedge clk);   // idle
      chk("R2", "busy after", busy, 0);
      chk("R3", "done after", done, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      // R1: reset state
      chk("R1", "reset pins", {busy, done, latch_stb, ad_oe, rd_n, wr_lo_n, upper_n}, 7'b0000111);
      req_valid = 1'b1;
      @(negedge clk);
      chk("R1", "request ignored in reset", {busy, latch_stb}, 2'b00);
      req_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "idle after reset", {busy, done, latch_stb, ad_oe, rd_n, wr_lo_n, upper_n}, 7'b0000111);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R11: request while busy is ignored
      cfg_muxed = 1'b1; cfg_upper_is_bhe = 1'b1;
      req_addr = 20'h30000; req_word = 1'b1; req_write = 1'b0; req_valid = 1'b1;
      @(negedge clk);   // address
      req_valid = 1'b0;
      @(negedge clk);   // data 1
      req_addr = 20'hCFFFF; req_valid = 1'b1;
      @(negedge clk);   // data 2
      req_valid = 1'b0;
      chk("R11", "bus_a_hi kept", bus_a_hi, 4'h3);
      @(negedge clk);   // recovery
      @(negedge clk);   // idle
      chk("R11", "no new cycle 1", {busy, latch_stb}, 2'b00);
      @(negedge clk);
      chk("R11", "no new cycle 2", {busy, latch_stb}, 2'b00);

      // R1: reset in the middle of a write
      req_addr = 20'h12345; req_write = 1'b1; req_wdata = 16'h5555; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);   // data 1
      chk("R1", "write strobe before reset", wr_lo_n, 0);
      rst_n = 1'b0;
      #1;
      chk("R1", "mid-cycle reset pins", {busy, done, latch_stb, ad_oe, rd_n, wr_lo_n, upper_n}, 7'b0000111);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "idle after mid reset", {busy, latch_stb}, 2'b00);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule